// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two phase signals of an incremental shaft encoder into a position count. Each phase is brought into the clock domain through a synchronizer. It then passes a stability filter, which rejects glitches shorter than a set number of clocks. Edges of the cleaned phases step a counter up or down. Whether a step counts up or down depends on the level of the opposite phase.

A two-bit mode input selects the resolution:
- Counting off.
- Counting on edges of one phase only, A or B (two counts per encoder cycle).
- Counting on edges of both phases (four counts per encoder cycle).

The count wraps between zero and a programmable reload value, with a one-cycle pulse on each wrap. A filtered index input can return the count to zero, giving an absolute reference. A direction flag tells which way the last step went.

Top module: `quad_pos_counter`

## Requirements
- R1: After reset, `count` is 0, `dir_down` is 0 and `wrap_pulse` is 0.
- R2: Each of phase A, phase B and the index input is synchronized through `SYNC_STAGES` flops. A new level is accepted only after it has been seen for `FILT_N` consecutive clocks. A shorter pulse leaves `count` unchanged.
- R3: With `mode` = 2'b10, only edges of filtered phase A step the count. A step is up when A differs from B after the edge, and down otherwise.
- R4: With `mode` = 2'b01, only edges of filtered phase B step the count. A step is up when A equals B after the edge, and down otherwise.
- R5: With `mode` = 2'b11, edges of either phase step the count, each using its own rule from R3 and R4. An edge on both phases in the same cycle is an invalid transition and produces no step.
- R6: With `mode` = 2'b00, or with `enable` low, `count` holds its value.
- R7: A step up taken while `count` >= `reload` loads 0 and raises `wrap_pulse` for exactly one cycle.
- R8: A step down taken while `count` = 0 loads `reload` and raises `wrap_pulse` for exactly one cycle.
- R9: `dir_down` is 1 after a step down and 0 after a step up. It keeps its value while no step is taken.
- R10: A rising edge of the filtered index input, while `enable` is high, clears `count` to 0 without a wrap pulse. A step in the same cycle is dropped.
- R11: `count` changes on the clock after the filtered edge, so a phase change reaches `count` `SYNC_STAGES + FILT_N + 1` clocks after it is first sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| phase_a | input | 1 | Encoder phase A, asynchronous |
| phase_b | input | 1 | Encoder phase B, asynchronous |
| index_in | input | 1 | Index pulse, asynchronous; tie low if unused |
| mode | input | 2 | 00 off, 01 phase-B edges, 10 phase-A edges, 11 both phases |
| reload | input | CNT_W | Upper wrap value of the count |
| enable | input | 1 | Counting and index clear enable |
| count | output | CNT_W | Position count |
| dir_down | output | 1 | Direction of the last step, 1 = down |
| wrap_pulse | output | 1 | One-cycle pulse on wrap in either direction |

## Verification
Two functions can fall in the same cycle: the index clear and a phase step. The bench provokes this by changing the index input and one phase on the same clock edge. Because both pass through filters of equal length, their filtered edges line up exactly. The clear must win: the count reads zero, no wrap pulse appears, and the direction flag keeps its earlier value. A second collision drives both phases at once in X4 mode, and the step is judged to be dropped. A cycle-by-cycle behavioural model in the bench is compared against all three outputs on every clock.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

  typedef enum logic [1:0] {
    QM_OFF  = 2'b00,
    QM_X2_B = 2'b01,
    QM_X2_A = 2'b10,
    QM_X4   = 2'b11
  } qmode_e;

  typedef struct packed {
    logic valid;
    logic up;
  } qstep_t;

  // Direction of a step caused by an edge on phase A (levels after the edge)
  function automatic logic dir_up_on_a(input logic a, input logic b);
    return a != b;
  endfunction

  // Direction of a step caused by an edge on phase B (levels after the edge)
  function automatic logic dir_up_on_b(input logic a, input logic b);
    return a == b;
  endfunction

endpackage

// File: rtl/qpc_filter.sv
module qpc_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_N      = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic filt_out
);
  localparam int CW = $clog2(FILT_N) + 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sync_lvl;
  logic [CW-1:0]          run_q;
  logic                   filt_q;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= raw_in;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_in};
      end
    end
  endgenerate

  assign sync_lvl = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      filt_q <= 1'b0;
    end else if (sync_lvl == filt_q) begin
      run_q <= '0;
    end else if (run_q == CW'(FILT_N - 1)) begin
      filt_q <= sync_lvl;
      run_q  <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign filt_out = filt_q;

  AST_FILT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_lvl == filt_q) |=> $stable(filt_q)); // R2
  AST_FILT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |-> (filt_q == $past(sync_lvl))); // R2

endmodule

// File: rtl/qpc_decode.sv
module qpc_decode
  import qpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fa,
  input  logic       fb,
  input  logic       fi,
  input  logic [1:0] mode,
  input  logic       enable,
  output qstep_t     step,
  output logic       clr
);
  logic   pa_q, pb_q, pi_q;
  logic   edge_a, edge_b;
  qmode_e qm;
  qstep_t st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q <= 1'b0;
      pb_q <= 1'b0;
      pi_q <= 1'b0;
    end else begin
      pa_q <= fa;
      pb_q <= fb;
      pi_q <= fi;
    end
  end

  assign edge_a = fa ^ pa_q;
  assign edge_b = fb ^ pb_q;
  assign qm     = qmode_e'(mode);
  assign clr    = enable & fi & ~pi_q;

  always_comb begin
    st = '0;
    if (enable) begin
      unique case (qm)
        QM_X2_A: if (edge_a) st = '{valid: 1'b1, up: dir_up_on_a(fa, fb)};
        QM_X2_B: if (edge_b) st = '{valid: 1'b1, up: dir_up_on_b(fa, fb)};
        QM_X4: begin
          if (edge_a && !edge_b)      st = '{valid: 1'b1, up: dir_up_on_a(fa, fb)};
          else if (edge_b && !edge_a) st = '{valid: 1'b1, up: dir_up_on_b(fa, fb)};
        end
        default: st = '0;
      endcase
    end
  end

  assign step = st;

  AST_OFF_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ((qm == QM_OFF) || !enable) |-> !step.valid); // R6
  AST_X4_DOUBLE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ((qm == QM_X4) && edge_a && edge_b) |-> !step.valid); // R5
  AST_X2A_IGNORES_B: assert property (@(posedge clk) disable iff (!rst_n)
    ((qm == QM_X2_A) && !edge_a) |-> !step.valid); // R3
  AST_X2B_IGNORES_A: assert property (@(posedge clk) disable iff (!rst_n)
    ((qm == QM_X2_B) && !edge_b) |-> !step.valid); // R4

endmodule

// File: rtl/qpc_core.sv
module qpc_core
  import qpc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  qstep_t           step,
  input  logic             clr,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             dir_down,
  output logic             wrap_pulse
);
  logic [CNT_W-1:0] cnt_q;
  logic             dir_q, wrap_q;
  logic             wrap_up, wrap_dn;

  function automatic logic [CNT_W-1:0] next_up(input logic [CNT_W-1:0] c,
                                               input logic [CNT_W-1:0] r);
    return (c >= r) ? '0 : c + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] next_dn(input logic [CNT_W-1:0] c,
                                               input logic [CNT_W-1:0] r);
    return (c == '0) ? r : c - 1'b1;
  endfunction

  assign wrap_up = step.valid &  step.up & (cnt_q >= reload);
  assign wrap_dn = step.valid & ~step.up & (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      dir_q  <= 1'b0;
      wrap_q <= 1'b0;
    end else if (clr) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else if (step.valid) begin
      dir_q  <= ~step.up;
      cnt_q  <= step.up ? next_up(cnt_q, reload) : next_dn(cnt_q, reload);
      wrap_q <= wrap_up | wrap_dn;
    end else begin
      wrap_q <= 1'b0;
    end
  end

  assign count      = cnt_q;
  assign dir_down   = dir_q;
  assign wrap_pulse = wrap_q;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step.valid && !clr) |=> ($stable(cnt_q) && !wrap_q)); // R6
  AST_WRAP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && step.valid && step.up && (cnt_q >= reload)) |=> ((cnt_q == '0) && wrap_q)); // R7
  AST_WRAP_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && step.valid && !step.up && (cnt_q == '0)) |=> ((cnt_q == $past(reload)) && wrap_q)); // R8
  AST_DIR_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && step.valid) |=> (dir_q == !$past(step.up))); // R9
  AST_INDEX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ((cnt_q == '0) && !wrap_q && $stable(dir_q))); // R10
  AST_WRAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_q && !step.valid) |=> !wrap_q); // R7

endmodule

// File: rtl/quad_pos_counter.sv
module quad_pos_counter
  import qpc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_N      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phase_a,
  input  logic             phase_b,
  input  logic             index_in,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] reload,
  input  logic             enable,
  output logic [CNT_W-1:0] count,
  output logic             dir_down,
  output logic             wrap_pulse
);
  localparam int N_IN = 3;

  logic [N_IN-1:0] raw_vec;
  logic [N_IN-1:0] filt_vec;
  qstep_t          step;
  logic            clr;

  assign raw_vec = {index_in, phase_b, phase_a};

  generate
    for (genvar g = 0; g < N_IN; g++) begin : g_in
      qpc_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_N(FILT_N)) u_filt (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (raw_vec[g]),
        .filt_out (filt_vec[g])
      );
    end
  endgenerate

  qpc_decode u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .fa     (filt_vec[0]),
    .fb     (filt_vec[1]),
    .fi     (filt_vec[2]),
    .mode   (mode),
    .enable (enable),
    .step   (step),
    .clr    (clr)
  );

  qpc_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (step),
    .clr        (clr),
    .reload     (reload),
    .count      (count),
    .dir_down   (dir_down),
    .wrap_pulse (wrap_pulse)
  );

  AST_CLR_BEATS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && step.valid) |=> (count == '0)); // R10

endmodule

// File: tb/quad_pos_counter_test.sv
`timescale 1ns/1ps
module quad_pos_counter_test;
  localparam int W = 16;
  localparam int SYNC = 2;
  localparam int FN = 3;

  logic clk = 0;
  logic rst_n = 0;
  logic ra = 0, rb = 0, ri = 0;
  logic [1:0] mode = 2'b00;
  logic [W-1:0] reload = 16'd100;
  logic enable = 0;
  logic [W-1:0] count;
  logic dir_down, wrap_pulse;

  always #5 clk = ~clk;

  quad_pos_counter #(.CNT_W(W), .SYNC_STAGES(SYNC), .FILT_N(FN)) uut (
    .clk(clk), .rst_n(rst_n), .phase_a(ra), .phase_b(rb), .index_in(ri),
    .mode(mode), .reload(reload), .enable(enable),
    .count(count), .dir_down(dir_down), .wrap_pulse(wrap_pulse)
  );

  int n_chk = 0, n_bad = 0;
  string cur_req = "R1";
  int wraps_seen = 0;
  bit done = 0;

  // Behavioural reference model: per input a sync queue, a stability run and a
  // filtered level; the step rule is taken from the requirements.
  bit q_sync [3][$];
  int run [3];
  bit flt [3];
  bit prv [3];
  int m_cnt = 0;
  bit m_dir = 0, m_wrap = 0;

  task automatic model_reset();
    for (int k = 0; k < 3; k++) begin
      q_sync[k] = {};
      for (int j = 0; j < SYNC; j++) q_sync[k].push_back(1'b0);
      run[k] = 0; flt[k] = 0; prv[k] = 0;
    end
    m_cnt = 0; m_dir = 0; m_wrap = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      bit ea, eb, rise, v, up, oldest;
      bit raw [3];
      raw[0] = ra; raw[1] = rb; raw[2] = ri;
      ea = flt[0] != prv[0];
      eb = flt[1] != prv[1];
      rise = flt[2] && !prv[2];
      v = 0; up = 0;
      if (enable) begin
        if (mode == 2'b10 && ea) begin v = 1; up = (flt[0] != flt[1]); end
        if (mode == 2'b01 && eb) begin v = 1; up = (flt[0] == flt[1]); end
        if (mode == 2'b11 && (ea != eb)) begin
          v = 1;
          up = ea ? (flt[0] != flt[1]) : (flt[0] == flt[1]);
        end
      end
      if (enable && rise) begin m_cnt = 0; m_wrap = 0; end
      else if (v) begin
        m_dir = !up;
        if (up) begin
          if (m_cnt >= int'(reload)) begin m_cnt = 0; m_wrap = 1; end
          else begin m_cnt = m_cnt + 1; m_wrap = 0; end
        end else begin
          if (m_cnt == 0) begin m_cnt = int'(reload); m_wrap = 1; end
          else begin m_cnt = m_cnt - 1; m_wrap = 0; end
        end
      end else m_wrap = 0;
      for (int k = 0; k < 3; k++) begin
        prv[k] = flt[k];
        oldest = q_sync[k][SYNC-1];
        if (oldest == flt[k]) run[k] = 0;
        else if (run[k] == FN - 1) begin flt[k] = oldest; run[k] = 0; end
        else run[k] = run[k] + 1;
        void'(q_sync[k].pop_back());
        q_sync[k].push_front(raw[k]);
      end
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_chk++;
      if (int'(count) != m_cnt || dir_down != m_dir || wrap_pulse != m_wrap) begin
        n_bad++;
        $display("FAIL %s model: count=%0d dir=%0b wrap=%0b expected count=%0d dir=%0b wrap=%0b",
                 cur_req, count, dir_down, wrap_pulse, m_cnt, m_dir, m_wrap);
      end
      if (wrap_pulse) wraps_seen++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  int qs = 0; // quadrature state index: 0=00,1=A only,2=both,3=B only
  task automatic qmove(input bit fwd);
    qs = fwd ? (qs + 1) % 4 : (qs + 3) % 4;
    ra = (qs == 1 || qs == 2);
    rb = (qs == 2 || qs == 3);
  endtask
  task automatic qsteps(input bit fwd, input int n);
    for (int i = 0; i < n; i++) begin qmove(fwd); hold(8); end
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=<20000", cyc);
      finish_run();
    end
  end

  initial begin
    int w0;
    hold(4);
    rst_n = 1;
    hold(1);
    cur_req = "R1";
    chk("R1 count", int'(count), 0);
    chk("R1 dir_down", int'(dir_down), 0);
    chk("R1 wrap_pulse", int'(wrap_pulse), 0);

    cur_req = "R3"; mode = 2'b10; enable = 1; reload = 16'd100;
    qsteps(1, 8);
    chk("R3 X2-A forward", int'(count), 4);
    chk("R9 up dir", int'(dir_down), 0);
    qsteps(0, 4);
    chk("R3 X2-A reverse", int'(count), 2);
    chk("R9 down dir", int'(dir_down), 1);

    cur_req = "R4"; mode = 2'b01;
    qsteps(1, 8);
    chk("R4 X2-B forward", int'(count), 6);
    chk("R9 up dir again", int'(dir_down), 0);

    cur_req = "R5"; mode = 2'b11;
    qsteps(1, 8);
    chk("R5 X4 forward", int'(count), 14);
    ra = ~ra; rb = ~rb; hold(10);
    chk("R5 double edge dropped", int'(count), 14);
    ra = ~ra; rb = ~rb; hold(10);
    chk("R5 double edge back dropped", int'(count), 14);

    cur_req = "R2";
    ra = ~ra; hold(2); ra = ~ra; hold(10);
    chk("R2 short glitch ignored", int'(count), 14);

    cur_req = "R11";
    qmove(1);
    hold(SYNC + FN);
    chk("R11 not yet counted", int'(count), 14);
    hold(1);
    chk("R11 counted on time", int'(count), 15);
    hold(4);

    cur_req = "R6"; mode = 2'b00;
    qsteps(1, 4);
    chk("R6 mode off holds", int'(count), 15);
    mode = 2'b11; enable = 0;
    qsteps(1, 4);
    chk("R6 disable holds", int'(count), 15);

    cur_req = "R7"; enable = 1; reload = 16'd5;
    w0 = wraps_seen;
    qsteps(1, 1);
    chk("R7 wrap to zero", int'(count), 0);
    chk("R7 one wrap pulse", wraps_seen - w0, 1);

    cur_req = "R8";
    w0 = wraps_seen;
    qsteps(0, 1);
    chk("R8 wrap to reload", int'(count), 5);
    chk("R8 one wrap pulse", wraps_seen - w0, 1);
    chk("R9 dir after wrap down", int'(dir_down), 1);
    qsteps(0, 1);
    chk("R8 plain decrement", int'(count), 4);

    cur_req = "R10";
    ri = 1; hold(8); ri = 0; hold(8);
    chk("R10 index clears", int'(count), 0);
    qsteps(1, 3);
    chk("R10 count before collision", int'(count), 3);
    w0 = wraps_seen;
    ri = 1; qmove(1); hold(10);
    chk("R10 clear beats step", int'(count), 0);
    chk("R10 no wrap on clear", wraps_seen - w0, 0);
    chk("R10 dir kept", int'(dir_down), 0);
    ri = 0; hold(8);
    qsteps(1, 1);
    chk("R10 counting resumes", int'(count), 1);

    hold(4);
    finish_run();
  end
endmodule